// File: doc/BRIEF.md
# FIFO DMA handshake controller

This block runs the host side of a DMA link between a byte-wide FIFO and a host data bus that is either 8 or 16 bits wide. Software loads a byte count and picks a direction. The block then raises a request whenever enough bytes, or enough free space, exist for the next move. It accepts the host's acknowledge and strobes, and tells the FIFO how many bytes to pop or push on each accepted strobe. In the read direction it places FIFO bytes on the 16-bit output bus, and it produces one odd-parity bit per byte lane.

Three stored option bits change the handshake. The first is hold-last. In 16-bit mode it keeps the final byte of an odd count out of DMA, so the host must take that byte from the FIFO directly. When hold-last is clear, that byte goes out as a padded word instead. The second and third are burst and ack-hold. When both are set, the request waits until eight bytes can move. It then stays up for the whole burst while the host keeps its acknowledge asserted. A lone burst or ack-hold bit gives the ordinary one-strobe-per-request handshake.

Top module: `fifo_dma_hs`

## Requirements
- R1: Hard reset (rst_n low) leaves dreq=0, done=0, fifo_pop=0 and fifo_push=0, and clears the three option bits. A soft_rst pulse also clears the option bits, so a later odd 16-bit transfer requests its final byte.
- R2: In 8-bit mode (wide=0), each accepted strobe moves exactly one byte (pop or push count 1). The byte sits on bus_out[7:0] and bus_out[15:8] is 0x00.
- R3: In 16-bit mode, each accepted strobe moves two bytes (count 2). The first FIFO byte (fifo_head[7:0]) is on bus_out[7:0] and the second on bus_out[15:8]. bus_par[i] is odd parity over byte lane i. Pop and push are never nonzero together.
- R4: With hold-last set, wide=1 and an odd remaining count, dreq never rises for the final byte. done stays 0 until host_take is pulsed, and that pulse clears the last byte from the count.
- R5: With hold-last clear, the final odd byte of a 16-bit transfer is requested. It appears as {0xFF, byte}, with bus_par[1]=1, and pops one byte.
- R6: Hold-last has no effect in 8-bit mode, and none when bytectl and byte_order are both set.
- R7: In per-strobe mode, dreq goes low in the cycle after each accepted strobe. It rises again one cycle later if data or space still permits.
- R8: In per-strobe mode, one strobe is accepted per dack assertion. A further strobe while dack stays high moves nothing.
- R9: In burst mode with direction write, dreq rises only when fifo_free >= min(8, remaining bytes).
- R10: In burst mode with direction read, dreq rises only when fifo_fill >= 8 and more than 7 bytes remain, or when fifo_fill covers all remaining bytes.
- R11: In burst mode, dreq stays high and every strobe under one continuous dack is accepted until 8 bytes have moved. Only then does dreq drop.
- R12: With only one of the burst and ack-hold bits set, the handshake is per-strobe, exactly as with both bits clear.
- R13: The count drops by the bytes moved per accepted strobe. dreq is low whenever the count is zero, and done goes high once a loaded count reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset of the option bits |
| cfg_we | input | 1 | Load the three option bits |
| cfg_hold_last | input | 1 | Hold-last option value |
| cfg_burst8 | input | 1 | Burst option value |
| cfg_hold_ack | input | 1 | Ack-hold option value |
| dir_rd | input | 1 | 1: FIFO to host, 0: host to FIFO |
| wide | input | 1 | 1: 16-bit host bus, 0: 8-bit |
| bytectl | input | 1 | Byte-control bus mode selected |
| byte_order | input | 1 | Byte-order select bit |
| start | input | 1 | Load start_count and begin a transfer |
| start_count | input | CNT_W | Transfer length in bytes |
| fifo_fill | input | FILL_W | Bytes held in the FIFO |
| fifo_free | input | FILL_W | Free byte slots in the FIFO |
| fifo_head | input | 16 | Next two FIFO bytes, first byte in [7:0] |
| dreq | output | 1 | DMA request |
| dack | input | 1 | DMA acknowledge |
| rd_stb | input | 1 | Host read strobe |
| wr_stb | input | 1 | Host write strobe |
| host_take | input | 1 | Host moved the held last byte directly |
| bus_out | output | 16 | Read data to host |
| bus_par | output | 2 | Odd parity per byte lane of bus_out |
| fifo_pop | output | 2 | Bytes to pop this cycle |
| fifo_push | output | 2 | Bytes to push this cycle |
| done | output | 1 | Loaded count has reached zero |

## Verification
Two functions can land on the same clock edge. The strobe that moves the last bytes also drives the count to zero, and in that same edge the request logic would normally re-arm because the FIFO still has data. The bench provokes this by strobing the final beat with the fill held high. It passes only if dreq is low and done is high in the next cycle. The same pairing happens at a burst's last strobe, where the burst counter empties while space for another burst already exists. The bench passes that case only if dreq shows a one-cycle gap before it rises again.

// File: rtl/fdh_pkg.sv
package fdh_pkg;

   typedef struct packed {
      logic hold_last;
      logic burst8;
      logic hold_ack;
   } fdh_cfg_t;

   function automatic logic odd_par(input logic [7:0] b);
      return ~(^b);
   endfunction

endpackage

// File: rtl/fdh_cfg_reg.sv
module fdh_cfg_reg
   import fdh_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      soft_rst,
   input  logic      cfg_we,
   input  fdh_cfg_t  cfg_d,
   output fdh_cfg_t  cfg_q
);
   // R1: both resets clear every option bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_q <= '0;
      else if (soft_rst) cfg_q <= '0;
      else if (cfg_we)   cfg_q <= cfg_d;
   end
endmodule

// File: rtl/fdh_counter.sv
module fdh_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] start_count,
   input  logic             dec_en,
   input  logic [1:0]       dec_amt,
   output logic [CNT_W-1:0] rem,
   output logic             loaded
);
   // R13: byte count, one or two per accepted beat
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem    <= '0;
         loaded <= 1'b0;
      end else if (start) begin
         rem    <= start_count;
         loaded <= 1'b1;
      end else if (dec_en) begin
         rem    <= rem - CNT_W'(dec_amt);
      end
   end
endmodule

// File: rtl/fdh_req.sv
module fdh_req #(
   parameter int CNT_W       = 16,
   parameter int FILL_W      = 5,
   parameter int BURST_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              dir_rd,
   input  logic              wide,
   input  logic              hold_odd,
   input  logic              burst_mode,
   input  logic [CNT_W-1:0]  rem,
   input  logic [FILL_W-1:0] fill,
   input  logic [FILL_W-1:0] free,
   input  logic              dack,
   input  logic              rd_stb,
   input  logic              wr_stb,
   output logic              dreq,
   output logic              acc,
   output logic [1:0]        step,
   output logic              pad
);
   localparam int BL_W  = $clog2(BURST_BYTES + 1);
   localparam int CMP_W = (CNT_W > FILL_W) ? CNT_W : FILL_W;

   logic [CNT_W-1:0] req_rem, need;
   logic [CMP_W-1:0] avail_x;
   logic             go_norm, go_burst, stb, fresh_now;
   logic             dreq_q, fresh_q, dack_q;
   logic [BL_W-1:0]  left_q, left_n;

   always_comb begin
      // R4: a held odd byte is never part of the DMA count
      req_rem = (hold_odd && rem[0]) ? rem - CNT_W'(1) : rem;
      step    = (!wide || req_rem == CNT_W'(1)) ? 2'd1 : 2'd2;
      pad     = wide && (req_rem == CNT_W'(1));
      need    = (req_rem >= CNT_W'(BURST_BYTES)) ? CNT_W'(BURST_BYTES) : req_rem;
      avail_x = CMP_W'(dir_rd ? fill : free);
      go_norm  = (req_rem != '0) && (avail_x >= CMP_W'(step));
      // R9 R10: burst waits for min(burst, remaining) bytes
      go_burst = (req_rem != '0) && (avail_x >= CMP_W'(need));
      stb       = dir_rd ? rd_stb : wr_stb;
      fresh_now = fresh_q || (dack && !dack_q);
      // R8 R11: per-strobe needs a fresh acknowledge, burst does not
      acc = dreq_q && dack && stb && (burst_mode || fresh_now);
      if (!burst_mode || start)  left_n = '0;
      else if (left_q != '0)     left_n = acc ? left_q - BL_W'(step) : left_q;
      else if (go_burst)         left_n = BL_W'(need);
      else                       left_n = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dreq_q  <= 1'b0;
         fresh_q <= 1'b0;
         dack_q  <= 1'b0;
         left_q  <= '0;
      end else begin
         dack_q  <= dack;
         fresh_q <= dack && fresh_now && !acc;
         left_q  <= left_n;
         // R7: per-strobe request drops for a cycle after each beat
         if (start)           dreq_q <= 1'b0;
         else if (burst_mode) dreq_q <= (left_n != '0);
         else                 dreq_q <= go_norm && !acc;
      end
   end

   assign dreq = dreq_q;
endmodule

// File: rtl/fdh_lane.sv
module fdh_lane
   import fdh_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic               dir_rd,
   input  logic               wide,
   input  logic               pad,
   input  logic               acc,
   input  logic [1:0]         step,
   input  logic [8*LANES-1:0] head,
   output logic [8*LANES-1:0] bus_out,
   output logic [LANES-1:0]   bus_par,
   output logic [1:0]         fifo_pop,
   output logic [1:0]         fifo_push
);
   always_comb begin
      bus_out[7:0] = head[7:0];
      // R5: padded final word fills upper lanes with ones; R2: 8-bit idles at zero
      bus_out[8*LANES-1:8] = pad ? '1 : (wide ? head[8*LANES-1:8] : '0);
   end

   for (genvar i = 0; i < LANES; i++) begin : g_par
      // R3: odd parity per lane
      assign bus_par[i] = odd_par(bus_out[8*i +: 8]);
   end

   assign fifo_pop  = (acc &&  dir_rd) ? step : 2'd0;
   assign fifo_push = (acc && !dir_rd) ? step : 2'd0;
endmodule

// File: rtl/fifo_dma_hs.sv
module fifo_dma_hs
   import fdh_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int FILL_W      = 5,
   parameter int BURST_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              cfg_we,
   input  logic              cfg_hold_last,
   input  logic              cfg_burst8,
   input  logic              cfg_hold_ack,
   input  logic              dir_rd,
   input  logic              wide,
   input  logic              bytectl,
   input  logic              byte_order,
   input  logic              start,
   input  logic [CNT_W-1:0]  start_count,
   input  logic [FILL_W-1:0] fifo_fill,
   input  logic [FILL_W-1:0] fifo_free,
   input  logic [15:0]       fifo_head,
   output logic              dreq,
   input  logic              dack,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic              host_take,
   output logic [15:0]       bus_out,
   output logic [1:0]        bus_par,
   output logic [1:0]        fifo_pop,
   output logic [1:0]        fifo_push,
   output logic              done
);
   localparam int BL_W = $clog2(BURST_BYTES + 1);

   if (BURST_BYTES < 2 || (BURST_BYTES % 2) != 0) begin : g_bad_burst
      $error("BURST_BYTES must be even and at least 2");
   end
   if (FILL_W < BL_W) begin : g_bad_fill
      $error("FILL_W too narrow to count one burst");
   end
   if (CNT_W < BL_W) begin : g_bad_cnt
      $error("CNT_W too narrow to count one burst");
   end

   fdh_cfg_t         cfg_q;
   logic             hold_odd_w, burst_w, acc_w, pad_w, loaded_w, take_w;
   logic [1:0]       step_w;
   logic [CNT_W-1:0] rem_w;

   fdh_cfg_reg u_cfg (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_we(cfg_we),
      .cfg_d('{hold_last: cfg_hold_last, burst8: cfg_burst8, hold_ack: cfg_hold_ack}),
      .cfg_q(cfg_q)
   );

   // R6: hold-last only in 16-bit mode and not under byte control with byte order
   assign hold_odd_w = wide && cfg_q.hold_last && !(bytectl && byte_order);
   // R12: burst timing needs both bits
   assign burst_w    = cfg_q.burst8 && cfg_q.hold_ack;
   // R4: the host's direct access retires the held byte
   assign take_w     = host_take && hold_odd_w && loaded_w && (rem_w == CNT_W'(1));

   fdh_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .start(start), .start_count(start_count),
      .dec_en(acc_w || take_w), .dec_amt(acc_w ? step_w : 2'd1),
      .rem(rem_w), .loaded(loaded_w)
   );

   fdh_req #(.CNT_W(CNT_W), .FILL_W(FILL_W), .BURST_BYTES(BURST_BYTES)) u_req (
      .clk(clk), .rst_n(rst_n), .start(start), .dir_rd(dir_rd), .wide(wide),
      .hold_odd(hold_odd_w), .burst_mode(burst_w), .rem(rem_w),
      .fill(fifo_fill), .free(fifo_free), .dack(dack), .rd_stb(rd_stb),
      .wr_stb(wr_stb), .dreq(dreq), .acc(acc_w), .step(step_w), .pad(pad_w)
   );

   fdh_lane #(.LANES(2)) u_lane (
      .dir_rd(dir_rd), .wide(wide), .pad(pad_w), .acc(acc_w), .step(step_w),
      .head(fifo_head), .bus_out(bus_out), .bus_par(bus_par),
      .fifo_pop(fifo_pop), .fifo_push(fifo_push)
   );

   // R13
   assign done = loaded_w && (rem_w == '0);
endmodule

// File: rtl/fdh_chk.sv
module fdh_chk #(
   parameter int CNT_W  = 16,
   parameter int FILL_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              dreq,
   input logic              acc,
   input logic              burst_mode,
   input logic              hold_odd,
   input logic              dir_rd,
   input logic              wide,
   input logic [CNT_W-1:0]  rem,
   input logic [FILL_W-1:0] fill,
   input logic [FILL_W-1:0] free,
   input logic [1:0]        pop,
   input logic [1:0]        push,
   input logic [15:0]       bus_out,
   input logic [1:0]        bus_par
);
   // R13
   dreq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rem == '0) |-> !dreq);

   // R2
   pop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pop) <= int'(fill));

   // R9
   push_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(push) <= int'(free));

   // R3
   one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((pop != 2'd0) && (push != 2'd0)));

   // R7
   req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !burst_mode) |=> !dreq);

   // R11
   burst_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_mode && $past(burst_mode) && !$past(start) && $fell(dreq)) |-> $past(acc));

   // R5
   pad_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && dir_rd && wide && pop == 2'd1) |-> (bus_out[15:8] == 8'hFF && bus_par[1]));

   // R4
   held_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_odd && rem == CNT_W'(1) && !dreq) |=> !dreq);
endmodule

bind fifo_dma_hs fdh_chk #(.CNT_W(CNT_W), .FILL_W(FILL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .dreq(dreq), .acc(acc_w),
   .burst_mode(burst_w), .hold_odd(hold_odd_w), .dir_rd(dir_rd), .wide(wide),
   .rem(rem_w), .fill(fifo_fill), .free(fifo_free), .pop(fifo_pop),
   .push(fifo_push), .bus_out(bus_out), .bus_par(bus_par)
);

// File: tb/fifo_dma_hs_test.sv
`timescale 1ns/100ps
module fifo_dma_hs_test;
   localparam int CNT_W  = 16;
   localparam int FILL_W = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              soft_rst = 1'b0, cfg_we = 1'b0;
   logic              cfg_hold_last = 1'b0, cfg_burst8 = 1'b0, cfg_hold_ack = 1'b0;
   logic              dir_rd = 1'b1, wide = 1'b0, bytectl = 1'b0, byte_order = 1'b0;
   logic              start = 1'b0;
   logic [CNT_W-1:0]  start_count = '0;
   logic [FILL_W-1:0] fifo_fill = '0, fifo_free = '0;
   logic [15:0]       fifo_head = '0;
   logic              dack = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0, host_take = 1'b0;
   logic              dreq, done;
   logic [15:0]       bus_out;
   logic [1:0]        bus_par, fifo_pop, fifo_push;

   int checks = 0;
   int errors = 0;
   bit fin = 1'b0;

   always #2.5 clk = ~clk;

   fifo_dma_hs #(.CNT_W(CNT_W), .FILL_W(FILL_W)) uut (.*);

   // fields: [44] wide, [43:36] count, [35:20] head, [19:4] bus, [3:2] par, [1:0] pop
   localparam logic [44:0] VEC [5] = '{
      {1'b0, 8'd5, 16'h1234, 16'h0034, 2'b10, 2'd1},   // R2
      {1'b1, 8'd4, 16'hA55A, 16'hA55A, 2'b11, 2'd2},   // R3
      {1'b1, 8'd1, 16'h7707, 16'hFF07, 2'b10, 2'd1},   // R5
      {1'b1, 8'd3, 16'h0180, 16'h0180, 2'b00, 2'd2},   // R3
      {1'b0, 8'd1, 16'hFFFE, 16'h00FE, 2'b10, 2'd1}    // R2
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic start_xfer(input int n);
      start = 1'b1;
      start_count = CNT_W'(n);
      tick();
      start = 1'b0;
   endtask

   task automatic load_cfg(input logic h, input logic b, input logic a);
      cfg_hold_last = h; cfg_burst8 = b; cfg_hold_ack = a; cfg_we = 1'b1;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!fin) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         finish_run();
      end
   end

   initial begin
      tick(); tick();
      // R1: hard reset state
      chk("R1 dreq after reset", 32'(dreq), 0);
      chk("R1 done after reset", 32'(done), 0);
      chk("R1 pop after reset", 32'(fifo_pop), 0);
      chk("R1 push after reset", 32'(fifo_push), 0);
      rst_n = 1'b1;
      tick();

      // table walk: R2 R3 R5 data lanes, parity, pop counts
      dir_rd = 1'b1; fifo_fill = 5'd16;
      for (int i = 0; i < 5; i++) begin
         wide = VEC[i][44];
         fifo_head = VEC[i][35:20];
         start_xfer(int'(VEC[i][43:36]));
         tick();
         chk("R7 table dreq up", 32'(dreq), 1);
         dack = 1'b1; rd_stb = 1'b1;
         #1;
         chk("R2 R3 R5 table bus", 32'(bus_out), 32'(VEC[i][19:4]));
         chk("R3 table parity", 32'(bus_par), 32'(VEC[i][3:2]));
         chk("R2 R3 table pop", 32'(fifo_pop), 32'(VEC[i][1:0]));
         tick();
         dack = 1'b0; rd_stb = 1'b0;
         tick();
      end

      // R7 R8 R13: per-strobe handshake, 8-bit, three bytes
      wide = 1'b0; fifo_head = 16'h0011;
      start_xfer(3);
      tick();
      chk("R7 dreq up", 32'(dreq), 1);
      dack = 1'b1; rd_stb = 1'b1;
      #1 chk("R2 first pop", 32'(fifo_pop), 1);
      tick();
      rd_stb = 1'b0;
      chk("R7 gap after strobe", 32'(dreq), 0);
      tick();
      chk("R7 request returns", 32'(dreq), 1);
      rd_stb = 1'b1;
      #1 chk("R8 strobe without new dack", 32'(fifo_pop), 0);
      tick();
      rd_stb = 1'b0; dack = 1'b0;
      tick();
      dack = 1'b1; rd_stb = 1'b1;
      #1 chk("R8 new dack accepted", 32'(fifo_pop), 1);
      tick();
      dack = 1'b0; rd_stb = 1'b0;
      tick();
      chk("R7 dreq for last byte", 32'(dreq), 1);
      dack = 1'b1; rd_stb = 1'b1;
      #1 chk("R13 last pop", 32'(fifo_pop), 1);
      tick();
      dack = 1'b0; rd_stb = 1'b0;
      chk("R13 done at zero", 32'(done), 1);
      chk("R13 no dreq at zero", 32'(dreq), 0);
      tick();
      chk("R13 dreq stays low", 32'(dreq), 0);

      // R4: held odd byte in 16-bit mode
      load_cfg(1'b1, 1'b0, 1'b0);
      wide = 1'b1; fifo_head = 16'h2211;
      start_xfer(3);
      tick();
      chk("R4 dreq for word", 32'(dreq), 1);
      dack = 1'b1; rd_stb = 1'b1;
      #1 chk("R4 word pop", 32'(fifo_pop), 2);
      tick();
      dack = 1'b0; rd_stb = 1'b0;
      tick(); tick();
      chk("R4 no dreq for held byte", 32'(dreq), 0);
      chk("R4 not done before take", 32'(done), 0);
      host_take = 1'b1;
      tick();
      host_take = 1'b0;
      chk("R4 done after host take", 32'(done), 1);

      // R6: hold-last bypassed in 8-bit mode
      wide = 1'b0;
      start_xfer(1);
      tick();
      chk("R6 8-bit last byte requested", 32'(dreq), 1);
      dack = 1'b1; rd_stb = 1'b1;
      #1 chk("R6 8-bit pop", 32'(fifo_pop), 1);
      tick();
      dack = 1'b0; rd_stb = 1'b0;
      // R6: bypassed under byte control with byte order
      wide = 1'b1; bytectl = 1'b1; byte_order = 1'b1; fifo_head = 16'h003C;
      start_xfer(1);
      tick();
      chk("R6 byte-control last byte requested", 32'(dreq), 1);
      dack = 1'b1; rd_stb = 1'b1;
      #1 chk("R6 R5 padded word", 32'(bus_out), 32'h0000FF3C);
      chk("R6 pad pop", 32'(fifo_pop), 1);
      tick();
      dack = 1'b0; rd_stb = 1'b0; bytectl = 1'b0; byte_order = 1'b0;

      // R1: soft reset clears hold-last
      soft_rst = 1'b1;
      tick();
      soft_rst = 1'b0;
      start_xfer(1);
      tick();
      chk("R1 soft reset cleared hold-last", 32'(dreq), 1);

      // R12: burst bit alone keeps per-strobe handshake
      load_cfg(1'b0, 1'b1, 1'b0);
      dir_rd = 1'b0; wide = 1'b0; fifo_free = 5'd1;
      start_xfer(4);
      tick();
      chk("R12 request with one free slot", 32'(dreq), 1);
      dack = 1'b1; wr_stb = 1'b1;
      #1 chk("R12 push one", 32'(fifo_push), 1);
      tick();
      wr_stb = 1'b0;
      tick();
      wr_stb = 1'b1;
      #1 chk("R12 held dack not reused", 32'(fifo_push), 0);
      tick();
      dack = 1'b0; wr_stb = 1'b0;

      // R9 R11: burst write
      load_cfg(1'b0, 1'b1, 1'b1);
      wide = 1'b1; fifo_free = 5'd7;
      start_xfer(20);
      tick(); tick();
      chk("R9 no burst with 7 free", 32'(dreq), 0);
      fifo_free = 5'd8;
      tick();
      chk("R9 burst with 8 free", 32'(dreq), 1);
      dack = 1'b1; wr_stb = 1'b1;
      for (int k = 0; k < 4; k++) begin
         #1 chk("R11 burst push word", 32'(fifo_push), 2);
         tick();
         if (k < 3) chk("R11 dreq held in burst", 32'(dreq), 1);
      end
      dack = 1'b0; wr_stb = 1'b0;
      chk("R11 dreq drops after 8 bytes", 32'(dreq), 0);
      tick();
      chk("R9 next burst rearms", 32'(dreq), 1);

      // R10: burst read
      dir_rd = 1'b1; wide = 1'b0; fifo_fill = 5'd7;
      start_xfer(20);
      tick(); tick();
      chk("R10 no burst with 7 full", 32'(dreq), 0);
      fifo_fill = 5'd8;
      tick();
      chk("R10 burst with 8 full", 32'(dreq), 1);
      fifo_fill = 5'd4;
      start_xfer(5);
      tick(); tick();
      chk("R10 end short of remaining", 32'(dreq), 0);
      fifo_fill = 5'd5;
      tick();
      chk("R10 end covers remaining", 32'(dreq), 1);

      fin = 1'b1;
      finish_run();
   end
endmodule